// File: doc/BRIEF.md
# Interrupt Pending and Mask Register Bank

This block holds the request-side state of a 64-input interrupt controller. Each clock it captures the level of every interrupt source into a pending register. A 64-bit mask register selects which pending sources may pass on as requests. The block drives a per-source vector of enabled requests and a single flag that is high when any enabled request exists. Priority, level arbitration and vector generation sit downstream and are not part of the block.

Software reaches the state through a plain register port: a write strobe, a 12-bit byte offset, 32-bit write data and 32-bit read data. The read data is a combinational decode of the offset. Each 64-bit register appears as two 32-bit words. The mask is active-high: a set bit blocks its source. Setting bit 0 of the mask in a single write is a shortcut that blocks every source at once. Source 0 is reserved and can never raise a request.

Top module: `irq_pend_mask`

## Requirements
- R1: After reset, both mask words read 0xFFFFFFFF, and `irq_req` and `irq_any` are 0.
- R2: For each source n in 63..1, `irq_req[n]` equals pending[n] AND NOT mask[n]. A change on `irq_src` reaches `irq_req` two rising edges later.
- R3: A write to the low mask word (offset 0x70C) with `bus_wdata[0]` = 1 sets all 64 mask bits to 1 in that same cycle, whatever the other data bits are.
- R4: A write to the high mask word (offset 0x708) loads mask bits 63:32 and leaves bits 31:0 unchanged. A write to the low mask word with `bus_wdata[0]` = 0 loads mask bits 31:0 and leaves bits 63:32 unchanged. Both words read back what was stored.
- R5: The pending register captures `irq_src` on every rising edge. It reads back one edge after a source change (bits 63:32 at offset 0x700, bits 31:0 at offset 0x704), and this holds even while the source is masked.
- R6: Pending bit 0 always reads 0, and `irq_req[0]` is never 1.
- R7: The pending words are read-only. Writes to offsets 0x700 and 0x704 change no register.
- R8: A mask write affects `irq_req` one rising edge after the edge that accepts the write.
- R9: `irq_any` is 1 exactly when at least one bit of `irq_req` is 1, and it is aligned with `irq_req`.
- R10: A read from any offset other than the four register offsets returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, accepted on the rising edge |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_src | input | 64 | Interrupt source levels; bit 0 is unused |
| irq_req | output | 64 | Registered enabled-request vector |
| irq_any | output | 1 | Registered OR of all enabled requests |

## Verification
The bench targets four corner cases:
- Mask-all: it writes the low mask word with bit 0 set and random upper bits. A design that stores only the written word would leave the high half open and let requests through.
- Masked sources: it reads the pending words while the mask blocks the sources. A design that gates the pending bits with the mask would read zeros.
- Timing: it samples `irq_req` on the exact edge after a mask write and after a source change, so a design with one register stage too many or too few fails the check.
- Ignored accesses: it writes the pending words, reads unmapped offsets and drives source 0. A design that stores those writes, returns stale data or passes a request from source 0 shows a wrong value at the ports.

// File: rtl/irq_pm_pkg.sv
package irq_pm_pkg;

   // Register selected by the current bus offset.
   typedef enum logic [2:0] {
      SEL_NONE    = 3'd0,
      SEL_PEND_HI = 3'd1,
      SEL_PEND_LO = 3'd2,
      SEL_MASK_HI = 3'd3,
      SEL_MASK_LO = 3'd4
   } irq_reg_sel_e;

   // Default byte offsets of the four words.
   localparam int unsigned OFS_PEND_HI = 32'h700;
   localparam int unsigned OFS_PEND_LO = 32'h704;
   localparam int unsigned OFS_MASK_HI = 32'h708;
   localparam int unsigned OFS_MASK_LO = 32'h70C;

endpackage

// File: rtl/irq_pend_sampler.sv
module irq_pend_sampler #(
   parameter int unsigned NUM_SRC  = 64,
   parameter bit          RSVD_LSB = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   output logic [NUM_SRC-1:0] pend_o
);

   if (NUM_SRC < 2) begin : g_bad_num
      $error("irq_pend_sampler: NUM_SRC must be at least 2");
   end

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      if (RSVD_LSB && i == 0) begin : g_rsvd
         assign pend_o[i] = 1'b0;
      end else begin : g_smp
         logic smp_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) smp_q <= 1'b0;
            else        smp_q <= src_i[i];
         end
         assign pend_o[i] = smp_q;

         // R5: the pending bit takes the source level from the previous edge.
         a_r5_pend_follows_src: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> pend_o[i] == $past(src_i[i]));
      end
   end

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int unsigned DATA_W = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_hi_i,
   input  logic                wr_lo_i,
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [2*DATA_W-1:0] mask_o
);

   localparam int unsigned MW = 2 * DATA_W;

   if (DATA_W < 2) begin : g_bad_w
      $error("irq_mask_bank: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] hi_q, lo_q;
   logic              mask_all;

   assign mask_all = wr_lo_i && wdata_i[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '1;
         lo_q <= '1;
      end else if (mask_all) begin
         hi_q <= '1;
         lo_q <= '1;
      end else begin
         if (wr_hi_i) hi_q <= wdata_i;
         if (wr_lo_i) lo_q <= wdata_i;
      end
   end

   assign mask_o = {hi_q, lo_q};

   // R3: setting bit 0 through the low word closes every source.
   a_r3_mask_all: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo_i && wdata_i[0]) |=> (&mask_o));

   // R4: a high-word write loads the upper half and keeps the lower half.
   a_r4_hi_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi_i && !wr_lo_i) |=>
         (mask_o[MW-1:DATA_W] == $past(wdata_i)) && $stable(mask_o[DATA_W-1:0]));

   // R4: a low-word write without bit 0 keeps the upper half.
   a_r4_lo_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo_i && !wdata_i[0] && !wr_hi_i) |=>
         (mask_o[DATA_W-1:0] == $past(wdata_i)) && $stable(mask_o[MW-1:DATA_W]));

endmodule

// File: rtl/irq_req_gate.sv
module irq_req_gate #(
   parameter int unsigned NUM_SRC = 64,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] pend_i,
   input  logic [NUM_SRC-1:0] mask_i,
   output logic [NUM_SRC-1:0] req_o,
   output logic               any_o
);

   logic [NUM_SRC-1:0] req_d;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_and
      assign req_d[i] = pend_i[i] & ~mask_i[i];
   end

   if (REG_OUT) begin : g_reg
      logic [NUM_SRC-1:0] req_q;
      logic               any_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            req_q <= '0;
            any_q <= 1'b0;
         end else begin
            req_q <= req_d;
            any_q <= |req_d;
         end
      end
      assign req_o = req_q;
      assign any_o = any_q;

      // R2 and R8: the output shows last edge's pending and mask state.
      a_r2_req_gated: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> req_o == $past(pend_i & ~mask_i));
   end else begin : g_comb
      assign req_o = req_d;
      assign any_o = |req_d;
   end

endmodule

// File: rtl/irq_pend_mask.sv
module irq_pend_mask #(
   parameter int unsigned NUM_SRC     = 64,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned OFS_PEND_HI = irq_pm_pkg::OFS_PEND_HI,
   parameter int unsigned OFS_PEND_LO = irq_pm_pkg::OFS_PEND_LO,
   parameter int unsigned OFS_MASK_HI = irq_pm_pkg::OFS_MASK_HI,
   parameter int unsigned OFS_MASK_LO = irq_pm_pkg::OFS_MASK_LO
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [NUM_SRC-1:0] irq_src,
   output logic [NUM_SRC-1:0] irq_req,
   output logic               irq_any
);

   import irq_pm_pkg::*;

   localparam int unsigned WORD_BYTES = DATA_W / 8;

   if (NUM_SRC != 2 * DATA_W) begin : g_bad_split
      $error("irq_pend_mask: NUM_SRC must equal two data words");
   end
   if ((OFS_PEND_HI % WORD_BYTES) != 0 || (OFS_PEND_LO % WORD_BYTES) != 0 ||
       (OFS_MASK_HI % WORD_BYTES) != 0 || (OFS_MASK_LO % WORD_BYTES) != 0) begin : g_bad_align
      $error("irq_pend_mask: register offsets must be word aligned");
   end
   if (OFS_MASK_HI >= (1 << ADDR_W) || OFS_MASK_LO >= (1 << ADDR_W) ||
       OFS_PEND_HI >= (1 << ADDR_W) || OFS_PEND_LO >= (1 << ADDR_W)) begin : g_bad_range
      $error("irq_pend_mask: register offset exceeds address width");
   end

   irq_reg_sel_e        sel;
   logic [NUM_SRC-1:0]  pend;
   logic [NUM_SRC-1:0]  mask;

   always_comb begin
      if      (bus_addr == ADDR_W'(OFS_PEND_HI)) sel = SEL_PEND_HI;
      else if (bus_addr == ADDR_W'(OFS_PEND_LO)) sel = SEL_PEND_LO;
      else if (bus_addr == ADDR_W'(OFS_MASK_HI)) sel = SEL_MASK_HI;
      else if (bus_addr == ADDR_W'(OFS_MASK_LO)) sel = SEL_MASK_LO;
      else                                      sel = SEL_NONE;
   end

   irq_pend_sampler #(
      .NUM_SRC  (NUM_SRC),
      .RSVD_LSB (1'b1)
   ) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .src_i  (irq_src),
      .pend_o (pend)
   );

   irq_mask_bank #(
      .DATA_W (DATA_W)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi_i (bus_wr && sel == SEL_MASK_HI),
      .wr_lo_i (bus_wr && sel == SEL_MASK_LO),
      .wdata_i (bus_wdata),
      .mask_o  (mask)
   );

   irq_req_gate #(
      .NUM_SRC (NUM_SRC),
      .REG_OUT (1'b1)
   ) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend),
      .mask_i (mask),
      .req_o  (irq_req),
      .any_o  (irq_any)
   );

   always_comb begin
      unique case (sel)
         SEL_PEND_HI: bus_rdata = pend[NUM_SRC-1:DATA_W];
         SEL_PEND_LO: bus_rdata = pend[DATA_W-1:0];
         SEL_MASK_HI: bus_rdata = mask[NUM_SRC-1:DATA_W];
         SEL_MASK_LO: bus_rdata = mask[DATA_W-1:0];
         default:     bus_rdata = '0;
      endcase
   end

   // R6: the reserved source never produces a request.
   a_r6_src0_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req[0]);

   // R9: the summary flag agrees with the request vector.
   a_r9_any_matches: assert property (@(posedge clk) disable iff (!rst_n)
      irq_any == (|irq_req));

   // R7: a write to a pending word leaves the mask untouched.
   a_r7_pend_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && (sel == SEL_PEND_HI || sel == SEL_PEND_LO)) |=> $stable(mask));

endmodule

// File: tb/irq_pend_mask_tb.sv
`timescale 1ns/1ps
module irq_pend_mask_tb_top;

   localparam logic [11:0] A_PHI = 12'h700;
   localparam logic [11:0] A_PLO = 12'h704;
   localparam logic [11:0] A_MHI = 12'h708;
   localparam logic [11:0] A_MLO = 12'h70C;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [63:0] irq_src = '0;
   logic [63:0] irq_req;
   logic        irq_any;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [63:0] m_mask;
   logic [63:0] m_src;

   always #2 clk = ~clk;

   irq_pend_mask dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_src   (irq_src),
      .irq_req   (irq_req),
      .irq_any   (irq_any)
   );

   function automatic logic [63:0] exp_pend();
      return m_src & ~64'h1;
   endfunction

   function automatic logic [63:0] exp_req();
      return exp_pend() & ~m_mask;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5;
      d = bus_rdata;
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a == A_MLO) begin
         if (d[0]) m_mask = '1;
         else      m_mask[31:0] = d;
      end else if (a == A_MHI) begin
         m_mask[63:32] = d;
      end
   endtask

   task automatic set_src(input logic [63:0] s);
      @(negedge clk);
      irq_src = s;
      m_src = s;
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic chk_steady(input string tag);
      logic [31:0] h, l;
      chk({tag, " R2 req"}, irq_req, exp_req());
      chk({tag, " R9 any"}, {63'd0, irq_any}, {63'd0, |exp_req()});
      rd(A_MHI, h); rd(A_MLO, l);
      chk({tag, " R4 mask readback"}, {h, l}, m_mask);
      rd(A_PHI, h); rd(A_PLO, l);
      chk({tag, " R5 pend readback"}, {h, l}, exp_pend());
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] h, l;
      logic [63:0] prev, s;
      int unsigned seed;
      seed = $urandom(32'd2024);
      m_mask = '1;
      m_src = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(A_MHI, h); rd(A_MLO, l);
      chk("R1 mask after reset", {h, l}, 64'hFFFF_FFFF_FFFF_FFFF);
      chk("R1 req after reset", irq_req, 64'h0);
      chk("R1 any after reset", {63'd0, irq_any}, 64'h0);

      // R5 pending follows masked source one edge later
      @(negedge clk);
      irq_src = 64'hA5A5_0000_1234_5677; m_src = irq_src;
      @(negedge clk);
      rd(A_PHI, h); rd(A_PLO, l);
      chk("R5 pend while masked", {h, l}, exp_pend());
      chk("R5 masked gives no req", irq_req, 64'h0);

      // R7 writes to pending words are ignored
      wr(A_PHI, 32'h0F0F_0F0F);
      wr(A_PLO, 32'hFFFF_FFFE);
      rd(A_PHI, h); rd(A_PLO, l);
      chk("R7 pend unchanged", {h, l}, exp_pend());
      rd(A_MHI, h); rd(A_MLO, l);
      chk("R7 mask unchanged", {h, l}, m_mask);

      // R4 half writes, open everything
      wr(A_MHI, 32'h0000_0000);
      rd(A_MHI, h); rd(A_MLO, l);
      chk("R4 hi write keeps lo", {h, l}, 64'h0000_0000_FFFF_FFFF);
      wr(A_MLO, 32'h0000_0000);
      rd(A_MHI, h); rd(A_MLO, l);
      chk("R4 lo write keeps hi", {h, l}, 64'h0);
      settle();
      chk_steady("open");

      // R8 mask write latency
      prev = exp_req();
      wr(A_MHI, 32'hFFFF_0000);
      chk("R8 req unchanged on write edge", irq_req, prev);
      @(negedge clk);
      chk("R8 req updated one edge later", irq_req, exp_req());

      // R2 source change latency
      prev = exp_req();
      set_src(64'h0000_FFFF_FFFF_0000);
      @(negedge clk);
      chk("R2 req one edge after src", irq_req, prev);
      @(negedge clk);
      chk("R2 req two edges after src", irq_req, exp_req());

      // R6 reserved source 0
      wr(A_MHI, 32'h0); wr(A_MLO, 32'h0);
      set_src(64'h1);
      settle();
      chk("R6 src0 no req", irq_req, 64'h0);
      chk("R6 src0 no any", {63'd0, irq_any}, 64'h0);
      rd(A_PLO, l);
      chk("R6 pend bit0 zero", {32'd0, l}, 64'h0);

      // R3 mask-all with random upper bits
      set_src(64'hFFFF_FFFF_FFFF_FFFF);
      settle();
      chk("R3 open before mask-all", irq_req, 64'hFFFF_FFFF_FFFF_FFFE);
      wr(A_MLO, 32'h0000_0011);
      rd(A_MHI, h); rd(A_MLO, l);
      chk("R3 mask-all readback", {h, l}, 64'hFFFF_FFFF_FFFF_FFFF);
      @(negedge clk);
      chk("R3 mask-all req", irq_req, 64'h0);
      chk("R3 mask-all any", {63'd0, irq_any}, 64'h0);

      // R10 unmapped offsets
      rd(12'h710, l);
      chk("R10 unmapped 0x710", {32'd0, l}, 64'h0);
      rd(12'h000, l);
      chk("R10 unmapped 0x000", {32'd0, l}, 64'h0);
      rd(12'h706, l);
      chk("R10 unmapped 0x706", {32'd0, l}, 64'h0);

      // random mix
      for (int it = 0; it < 300; it++) begin
         int unsigned op = $urandom % 4;
         if (op == 0) begin
            s = {$urandom, $urandom};
            set_src(s);
         end else if (op == 1) begin
            wr(A_MHI, $urandom);
         end else begin
            logic [31:0] d = $urandom;
            d[0] = (($urandom % 8) == 0);
            wr(A_MLO, d);
         end
         settle();
         chk_steady("random");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule